// File: doc/BRIEF.md
# Data Clock Edge Finder by Sampling-Phase Sweep

This block measures how far apart, in fast-clock cycles, the returned data clocks of two multiplexed converters are. A sampling clock runs at the data-clock frequency through an external adjustable delay whose range covers one full period in `STEPS` equal steps. Because the sampling clock and the data clocks share a frequency, each data clock sampled at a fixed delay setting reads as a steady level. The controller samples both data clocks at every delay setting, from step 0 upward, and records for each clock the step at which its level turns from low to high.

After the sweep, the step difference is scaled by the number of fast-clock cycles in one data-clock period, rounded to the nearest whole cycle and folded into the range -1 to 2. A data path can then shift one converter's words by that many fast-clock cycles to line the two converters up. The delay element is outside the block: the controller asks for one step at a time and waits for an acknowledge.

Top module: `dclk_edge_finder`

## Requirements
- R1: After reset, `done_o`, `error_o`, `offset_valid_o` and `step_req_o` are low and `offset_o` is 3'b000.
- R2: A high `start_i` in the idle or finished state starts a sweep and clears `done_o`, `error_o` and `offset_valid_o` at the next edge. A `start_i` during a sweep has no effect on the step requests or on when the sweep completes.
- R3: Counting the edge that accepts `start_i` as edge 0, `step_req_o` is high for exactly one cycle after each edge 9k+8 for k = 0 to 254. That gives 255 single-cycle requests, each followed by an 8-cycle settle window.
- R4: An acknowledge counts only if it is high at one of the first 7 edges of a settle window. If it is missing, the sweep stops: `done_o` rises at edge 18 after a missing first acknowledge, with `error_o` high and `offset_valid_o` low.
- R5: The sample for each delay setting is taken in the last cycle of its settle window. A first sample at setting 0 is taken with no request, which gives 256 samples, indices 0 to 255. An input level must be steady for the last two cycles of the window.
- R6: A rise is accepted at index k only if the samples at k-2 and k-1 are 0 and the samples at k and k+1 are 1. Only the first accepted rise of a sweep is kept, so isolated single readings of either level are ignored.
- R7: When the sweep completes with no error, `edge_a_o` and `edge_b_o` hold the accepted rise index of channel A and channel B.
- R8: If either channel has no accepted rise after all 256 samples, `error_o` is high, `offset_valid_o` is low and `offset_o` is 3'b000 when `done_o` rises.
- R9: With d = edge_a - edge_b, the result is q = floor((d*RATIO + STEPS/2) / STEPS), with RATIO = 4 and STEPS = 256. q is reduced modulo 4 and a residue of 3 is reported as -1. `offset_o` is 3-bit two's complement (111, 000, 001, 010).
- R10: With no error, `done_o` rises exactly 2304 edges after edge 0 and stays high until the next `start_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a sweep |
| step_req_o | output | 1 | One-cycle request to advance the delay by one step |
| step_ack_i | input | 1 | Delay element reports that the step has been applied |
| samp_a_i | input | 1 | Synchronized sample of data clock A |
| samp_b_i | input | 1 | Synchronized sample of data clock B |
| done_o | output | 1 | Sweep finished, results held |
| error_o | output | 1 | Missing acknowledge or missing rise |
| offset_valid_o | output | 1 | `offset_o` is meaningful |
| offset_o | output | 3 | Cycle offset of A relative to B, -1 to 2 |
| edge_a_o | output | 8 | Rise step found for channel A |
| edge_b_o | output | 8 | Rise step found for channel B |

## Verification
The hardest situations to reach from the ports are those where the samples or the acknowledge sit exactly on a boundary. The first is a single stray reading that looks like a rise. The second is an acknowledge that arrives in the last settle cycle instead of one cycle earlier. The third is a rise placed so that the floor rounding flips between two results. The bench drives a behavioural delay element with a programmable acknowledge latency and can inject one flipped sample at a chosen delay setting. It places the edges of the two clocks at steps whose scaled difference lands just below and just at a half cycle. The mid-sweep start pulse and the restart from the finished state are covered by comparing the request and done pins against the model on every clock.

// File: rtl/def_pkg.sv
// Package: shared types for the data clock edge finder.
// Assumes nothing beyond IEEE 1800-2017.
package def_pkg;

    // Sweep controller states
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_WAIT = 3'd1,
        ST_REQ  = 3'd2,
        ST_CALC = 3'd3,
        ST_DONE = 3'd4
    } sweep_state_t;

    // Width of the reported cycle offset (range -1..2)
    localparam int OFF_W = 3;

endpackage

// File: rtl/def_sweep_ctrl.sv
// Module: def_sweep_ctrl
// Walks the external delay through STEPS settings. For each setting
// after the first it issues a one-cycle step request, then waits a
// settle window of SETTLE cycles. The acknowledge must be seen before
// the window's last cycle, and the sample strobe fires in that last
// cycle. A missing acknowledge ends the sweep with a timeout flag.
// Assumes SETTLE >= 2 and the delay starts at setting 0 on start.
module def_sweep_ctrl
    import def_pkg::*;
#(
    parameter int STEPS  = 256,
    parameter int SETTLE = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_i,
    input  logic                       step_ack_i,
    output logic                       step_req_o,
    output logic                       strobe_o,
    output logic [$clog2(STEPS)-1:0]   idx_o,
    output logic                       clear_o,
    output logic                       calc_o,
    output logic                       timeout_o,
    output logic                       done_o
);
    localparam int STEP_W = $clog2(STEPS);
    localparam int CNT_W  = $clog2(SETTLE);
    localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(SETTLE - 1);
    localparam logic [STEP_W-1:0] IDX_LAST = STEP_W'(STEPS - 1);

    sweep_state_t      state;
    logic [CNT_W-1:0]  cnt;
    logic [STEP_W-1:0] idx;
    logic              ack_seen;
    logic              timeout_q;
    logic              accept;
    logic              win_end;

    // A start is taken only when no sweep is running
    assign accept  = ((state == ST_IDLE) || (state == ST_DONE)) && start_i;
    // Last cycle of a settle window
    assign win_end = (state == ST_WAIT) && (cnt == CNT_LAST);

    // State, settle counter, step index and acknowledge tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            idx       <= '0;
            ack_seen  <= 1'b0;
            timeout_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE, ST_DONE: begin
                    if (start_i) begin
                        state     <= ST_WAIT;
                        cnt       <= '0;
                        idx       <= '0;
                        ack_seen  <= 1'b1;
                        timeout_q <= 1'b0;
                    end
                end
                ST_WAIT: begin
                    if (step_ack_i) begin
                        ack_seen <= 1'b1;
                    end
                    if (cnt == CNT_LAST) begin
                        if (!ack_seen) begin
                            timeout_q <= 1'b1;
                            state     <= ST_CALC;
                        end else if (idx == IDX_LAST) begin
                            state <= ST_CALC;
                        end else begin
                            state <= ST_REQ;
                        end
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                ST_REQ: begin
                    idx      <= idx + STEP_W'(1);
                    cnt      <= '0;
                    ack_seen <= 1'b0;
                    state    <= ST_WAIT;
                end
                ST_CALC: begin
                    state <= ST_DONE;
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    // Decoded controls for the trackers and the result stage
    assign step_req_o = (state == ST_REQ);
    assign strobe_o   = win_end && ack_seen;
    assign idx_o      = idx;
    assign clear_o    = accept;
    assign calc_o     = (state == ST_CALC);
    assign timeout_o  = timeout_q;
    assign done_o     = (state == ST_DONE);

endmodule

// File: rtl/def_edge_track.sv
// Module: def_edge_track
// Watches one channel's sample stream in sweep order and keeps the
// index of the first filtered low-to-high change. A change at index k
// counts only when samples k-2, k-1 read 0 and samples k, k+1 read 1.
// Assumes strobes arrive with idx_i counting up from 0 after clear_i.
module def_edge_track #(
    parameter int STEP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              strobe_i,
    input  logic              samp_i,
    input  logic [STEP_W-1:0] idx_i,
    output logic              found_o,
    output logic [STEP_W-1:0] edge_o
);
    // hist[0] is the sample one index back, hist[2] three back
    logic [2:0] hist;
    logic       hit;

    // Two lows followed by two highs, with a full window behind us
    assign hit = !found_o && (idx_i >= STEP_W'(3)) && (hist == 3'b001) && samp_i;

    // Sample history and first-rise capture
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            hist    <= 3'b000;
            found_o <= 1'b0;
            edge_o  <= '0;
        end else if (strobe_i) begin
            hist <= {hist[1:0], samp_i};
            if (hit) begin
                found_o <= 1'b1;
                edge_o  <= idx_i - STEP_W'(1);
            end
        end
    end

endmodule

// File: rtl/def_offset_calc.sv
// Module: def_offset_calc
// Turns the two rise steps into a whole number of fast-clock cycles.
// The step difference is scaled by RATIO, offset by half a period and
// divided by STEPS with floor. The result is taken modulo 4, with a
// residue of 3 reported as -1. All arithmetic is done modulo
// 2^(STEP_W+2), which is exact for the two bits kept.
// Assumes STEPS is a power of two.
module def_offset_calc
    import def_pkg::*;
#(
    parameter int STEP_W = 8,
    parameter int RATIO  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              calc_i,
    input  logic              timeout_i,
    input  logic              found_a_i,
    input  logic              found_b_i,
    input  logic [STEP_W-1:0] edge_a_i,
    input  logic [STEP_W-1:0] edge_b_i,
    output logic              valid_o,
    output logic              err_o,
    output logic [OFF_W-1:0]  offset_o
);
    localparam int X_W = STEP_W + 2;
    localparam logic [X_W-1:0] RATIO_X = X_W'(RATIO);
    localparam logic [X_W-1:0] HALF_X  = X_W'(1) << (STEP_W - 1);

    logic [X_W-1:0]   diff;
    logic [X_W-1:0]   scaled;
    logic [1:0]       wrap;
    logic             bad;
    logic [OFF_W-1:0] code;

    // Modular difference, scale, round and fold to two bits
    always_comb begin
        diff   = {2'b00, edge_a_i} - {2'b00, edge_b_i};
        scaled = diff * RATIO_X + HALF_X;
        wrap   = 2'(scaled >> STEP_W);
        code   = (wrap == 2'b11) ? {OFF_W{1'b1}} : {{(OFF_W-2){1'b0}}, wrap};
        bad    = timeout_i || !found_a_i || !found_b_i;
    end

    // Result registers, loaded once at the end of a sweep
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            valid_o  <= 1'b0;
            err_o    <= 1'b0;
            offset_o <= '0;
        end else if (calc_i) begin
            valid_o  <= !bad;
            err_o    <= bad;
            offset_o <= bad ? '0 : code;
        end
    end

endmodule

// File: rtl/dclk_edge_finder.sv
// Module: dclk_edge_finder (top)
// Sweeps an external sampling-clock delay across one data-clock period,
// finds the rising step of two sampled data clocks and reports their
// distance as a cycle offset in -1..2. Both sample inputs are re-timed
// once more here. The controller reads them in the last settle cycle.
// Assumes the sample inputs are already synchronized to clk.
module dclk_edge_finder
    import def_pkg::*;
#(
    parameter int STEPS  = 256,
    parameter int SETTLE = 8,
    parameter int RATIO  = 4,
    localparam int STEP_W = $clog2(STEPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic              step_req_o,
    input  logic              step_ack_i,
    input  logic              samp_a_i,
    input  logic              samp_b_i,
    output logic              done_o,
    output logic              error_o,
    output logic              offset_valid_o,
    output logic [OFF_W-1:0]  offset_o,
    output logic [STEP_W-1:0] edge_a_o,
    output logic [STEP_W-1:0] edge_b_o
);
    localparam int NCH = 2;

    logic              strobe;
    logic              clear;
    logic              calc;
    logic              timeout;
    logic [STEP_W-1:0] idx;
    logic [NCH-1:0]    samp_in;
    logic [NCH-1:0]    samp_q;
    logic [NCH-1:0]    found;
    logic [STEP_W-1:0] edges [NCH];

    assign samp_in = {samp_b_i, samp_a_i};

    // Re-time both sample inputs so the read is one clean register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp_q <= '0;
        end else begin
            samp_q <= samp_in;
        end
    end

    def_sweep_ctrl #(
        .STEPS  (STEPS),
        .SETTLE (SETTLE)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .step_ack_i (step_ack_i),
        .step_req_o (step_req_o),
        .strobe_o   (strobe),
        .idx_o      (idx),
        .clear_o    (clear),
        .calc_o     (calc),
        .timeout_o  (timeout),
        .done_o     (done_o)
    );

    // One edge tracker per data clock
    for (genvar ch = 0; ch < NCH; ch++) begin : g_track
        def_edge_track #(
            .STEP_W (STEP_W)
        ) u_track (
            .clk      (clk),
            .rst_n    (rst_n),
            .clear_i  (clear),
            .strobe_i (strobe),
            .samp_i   (samp_q[ch]),
            .idx_i    (idx),
            .found_o  (found[ch]),
            .edge_o   (edges[ch])
        );
    end

    def_offset_calc #(
        .STEP_W (STEP_W),
        .RATIO  (RATIO)
    ) u_calc (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (clear),
        .calc_i    (calc),
        .timeout_i (timeout),
        .found_a_i (found[0]),
        .found_b_i (found[1]),
        .edge_a_i  (edges[0]),
        .edge_b_i  (edges[1]),
        .valid_o   (offset_valid_o),
        .err_o     (error_o),
        .offset_o  (offset_o)
    );

    assign edge_a_o = edges[0];
    assign edge_b_o = edges[1];

endmodule

// File: rtl/def_checker.sv
// Module: def_checker
// Port-level properties of the edge finder, bound to the top module.
module def_checker #(
    parameter int STEP_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              step_req_o,
    input logic              done_o,
    input logic              error_o,
    input logic              offset_valid_o,
    input logic [2:0]        offset_o,
    input logic [STEP_W-1:0] edge_a_o,
    input logic [STEP_W-1:0] edge_b_o
);
    // R3: every step request lasts exactly one cycle
    a_r3_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        step_req_o |=> !step_req_o);

    // R2: no step request while the result is held
    a_r2_no_req_when_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !step_req_o);

    // R2: a start from the finished state drops done and the valid flag
    a_r2_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && start_i) |=> (!done_o && !offset_valid_o));

    // R10: done holds until a new start
    a_r10_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);

    // R8: a valid result only when finished without error
    a_r8_valid_needs_clean_done: assert property (@(posedge clk) disable iff (!rst_n)
        offset_valid_o |-> (done_o && !error_o));

    // R8: an invalid result reads as zero
    a_r8_invalid_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !offset_valid_o |-> (offset_o == 3'b000));

    // R9: only -1, 0, 1 or 2 are ever reported
    a_r9_offset_legal: assert property (@(posedge clk) disable iff (!rst_n)
        offset_valid_o |-> (offset_o == 3'b111 || offset_o == 3'b000 ||
                            offset_o == 3'b001 || offset_o == 3'b010));

    // R7: both rise steps hold steady while the result is held
    a_r7_edges_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> ($stable(edge_a_o) && $stable(edge_b_o)));

endmodule

bind dclk_edge_finder def_checker #(.STEP_W(STEP_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .step_req_o     (step_req_o),
    .done_o         (done_o),
    .error_o        (error_o),
    .offset_valid_o (offset_valid_o),
    .offset_o       (offset_o),
    .edge_a_o       (edge_a_o),
    .edge_b_o       (edge_b_o)
);

// File: tb/dclk_edge_finder_bench.sv
// Bench for dclk_edge_finder: a behavioural delay element with
// programmable acknowledge latency drives two modelled data clocks. A
// reference model predicts every pin on every clock.
module dclk_edge_finder_bench;
    localparam int STEPS  = 256;
    localparam int SETTLE = 8;
    localparam int RATIO  = 4;
    localparam int STEP_W = 8;
    localparam int FULL   = STEPS * (SETTLE + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic              step_req_o;
    logic              step_ack_i;
    logic              samp_a_i;
    logic              samp_b_i;
    logic              done_o;
    logic              error_o;
    logic              offset_valid_o;
    logic [2:0]        offset_o;
    logic [STEP_W-1:0] edge_a_o;
    logic [STEP_W-1:0] edge_b_o;

    int checks = 0;
    int fails  = 0;

    // Stimulus settings, driven only from the initial block
    int  pa = 40;
    int  pb = 40;
    int  glitch_at = -1;
    int  ack_lat = 2;
    logic arm = 1'b0;

    // Delay element state, owned by the model process
    int   dly = 0;
    int   pend = 0;
    logic ack_q = 1'b0;

    always #2.5 clk = ~clk;

    dclk_edge_finder #(
        .STEPS  (STEPS),
        .SETTLE (SETTLE),
        .RATIO  (RATIO)
    ) u_dclk_edge_finder (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start_i),
        .step_req_o     (step_req_o),
        .step_ack_i     (step_ack_i),
        .samp_a_i       (samp_a_i),
        .samp_b_i       (samp_b_i),
        .done_o         (done_o),
        .error_o        (error_o),
        .offset_valid_o (offset_valid_o),
        .offset_o       (offset_o),
        .edge_a_o       (edge_a_o),
        .edge_b_o       (edge_b_o)
    );

    // Level of a data clock sampled at delay d when it rises at p
    function automatic logic level(int d, int p);
        return (((d - p + STEPS) % STEPS) < STEPS / 2);
    endfunction

    assign samp_a_i   = level(dly, pa) ^ (dly == glitch_at);
    assign samp_b_i   = level(dly, pb);
    assign step_ack_i = ack_q;

    // Delay element: acknowledge and apply a step ack_lat cycles after a request
    always @(negedge clk) begin
        if (!arm) begin
            dly   <= 0;
            pend  <= 0;
            ack_q <= 1'b0;
        end else begin
            ack_q <= 1'b0;
            if (pend == 1) begin
                ack_q <= 1'b1;
                dly   <= (dly + 1) % STEPS;
            end
            if (step_req_o && ack_lat > 0) pend <= ack_lat;
            else if (pend > 0)             pend <= pend - 1;
        end
    end

    // Reference offset from the two rise steps
    function automatic int ref_offset(int ea, int eb);
        int y, q, m;
        y = (ea - eb) * RATIO + STEPS / 2;
        if (y >= 0) q = y / STEPS;
        else        q = -((-y + STEPS - 1) / STEPS);
        m = ((q % 4) + 4) % 4;
        return (m == 3) ? -1 : m;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // One sweep; the model predicts pins on every clock until done
    task automatic run_case(input int a, input int b, input int gl, input int lat,
                            input bit exp_err, input int done_at, input int mid_start);
        int exp_off;
        bit req_exp;
        bit errors_before;
        errors_before = 1'b0;
        @(negedge clk);
        arm = 1'b0; pa = a; pb = b; glitch_at = gl; ack_lat = lat;
        @(negedge clk);
        arm = 1'b1;
        start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        exp_off = ref_offset(a, b);
        // R2: the start edge clears the held result
        check(!done_o && !offset_valid_o && !error_o, "R2 start clears", int'(done_o), 0);
        for (int n = 1; n <= done_at; n++) begin
            @(posedge clk);
            @(negedge clk);
            start_i = (n == mid_start);
            req_exp = ((n % 9) == 8) && (n + 10 <= done_at);
            if (step_req_o !== req_exp) begin
                // R3: request timing
                check(1'b0, "R3 step request", int'(step_req_o), int'(req_exp));
                errors_before = 1'b1;
            end
            if (done_o !== (n >= done_at)) begin
                // R10 / R2: done timing (also under a mid-sweep start)
                check(1'b0, "R10 done timing", int'(done_o), int'(n >= done_at));
                errors_before = 1'b1;
            end
        end
        start_i = 1'b0;
        check(!errors_before, "R3 R10 per-clock pins", 0, 0);
        check(done_o === 1'b1, "R10 done", int'(done_o), 1);
        check(error_o === exp_err, "R8 R4 error", int'(error_o), int'(exp_err));
        check(offset_valid_o === !exp_err, "R8 valid", int'(offset_valid_o), int'(!exp_err));
        if (exp_err) begin
            check(offset_o === 3'b000, "R8 offset zero", int'(offset_o), 0);
        end else begin
            check(int'($signed(offset_o)) == exp_off, "R9 offset",
                  int'($signed(offset_o)), exp_off);
            check(int'(edge_a_o) == a, "R7 R6 edge a", int'(edge_a_o), a);
            check(int'(edge_b_o) == b, "R7 edge b", int'(edge_b_o), b);
        end
        // R10: done holds without a start
        repeat (3) @(negedge clk);
        check(done_o === 1'b1, "R10 done holds", int'(done_o), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!done_o && !error_o && !offset_valid_o && !step_req_o && offset_o == 3'b000,
              "R1 reset state", int'(done_o) + int'(step_req_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!done_o && !step_req_o, "R1 idle after reset", int'(done_o), 0);

        run_case(40, 40, -1, 2, 1'b0, FULL, 0);      // R9 zero offset
        run_case(104, 40, -1, 3, 1'b0, FULL, 500);   // R9 +1; R2 mid-sweep start ignored
        run_case(40, 170, -1, 2, 1'b0, FULL, 0);     // R9 negative difference folds to 2
        run_case(200, 10, -1, 2, 1'b0, FULL, 0);     // R9 residue 3 gives -1
        run_case(72, 40, -1, 2, 1'b0, FULL, 0);      // R9 exactly half a cycle rounds up
        run_case(71, 40, -1, 2, 1'b0, FULL, 0);      // R9 just under half rounds down
        run_case(100, 30, 60, 2, 1'b0, FULL, 0);     // R6 isolated high reading ignored
        run_case(130, 30, 180, 2, 1'b0, FULL, 0);    // R6 isolated low after the rise ignored
        run_case(0, 50, -1, 2, 1'b1, FULL, 0);       // R8 no qualified rise on channel A
        run_case(40, 90, -1, 8, 1'b1, 18, 0);        // R4 acknowledge in last cycle is too late
        run_case(60, 20, -1, 7, 1'b0, FULL, 0);      // R4 R5 latest accepted acknowledge

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule